// File: doc/BRIEF.md
# USB IN Endpoint Transmit Buffer Controller

This block holds the outgoing data of one device-side IN endpoint (bulk, interrupt or isochronous) and hands it out one packet per host IN token. Firmware loads bytes through a byte-wide write port and declares a packet ready with an arm strobe. When the automatic-arm option is on, the block arms a packet by itself once the packet reaches the maximum packet size. A flush strobe discards every buffered packet.

The store works in single-buffer mode, where the whole store holds one packet, or in double-buffer mode. In double-buffer mode the store splits into two halves. Each half has its own byte count and ready flag, and the halves are filled and drained in alternating order. The ready status seen by firmware always refers to the half being filled. So after one packet is armed, the status can read "not ready" while the store still holds data.

Tokens and handshakes arrive as single-cycle strobes. A token that finds a ready packet streams its bytes out, one per cycle. The packet is retired on the host acknowledge, or at its last byte in isochronous mode. Each retirement raises a one-cycle endpoint interrupt. A token that finds nothing ready gives a NAK pulse in non-isochronous mode. In isochronous mode it sets a sticky underrun flag and raises the same interrupt.

Top module: `in_ep_txbuf`

## Requirements
- R1: While reset is asserted and after it is released, `pkt_rdy`, `fifo_not_empty`, `iso_underrun`, `tok_nak`, `ep_irq` and `tx_valid` are 0.
- R2: A cycle with `fw_arm` high marks the packet in the fill buffer as ready, including a zero-length packet. `pkt_rdy` shows the ready flag of the fill buffer from the next cycle on.
- R3: With `cfg_autoset` = 1, the write that brings the fill buffer's count to MAX_PKT also arms that buffer at the same clock edge. A shorter packet, or any packet with `cfg_autoset` = 0, stays unarmed until `fw_arm`.
- R4: `fifo_not_empty` is 1 exactly when at least one byte is stored and not yet retired.
- R5: With `cfg_dbuf` = 1, each buffer is one half of the store (DEPTH/2 bytes) and the halves are used in alternating order. After one packet is armed, `pkt_rdy` reads 0 while `fifo_not_empty` reads 1. When the last stored packet has been retired, `fifo_not_empty` returns to 0 by itself.
- R6: A `tok_in` with the oldest armed packet ready makes `tx_valid` high from the next cycle. The packet's bytes appear on `tx_data` in write order, one per cycle, with `tx_last` on the final byte. A zero-length packet sends no bytes. A `tok_in` that arrives while the block waits for an acknowledge sends the same packet again.
- R7: A packet is retired when `tok_ack` arrives after it has been sent (non-isochronous), or at its last byte (isochronous). Retiring frees its buffer, and `ep_irq` pulses for exactly one cycle in the cycle after.
- R8: With `cfg_iso` = 1, a `tok_in` that finds no ready packet sets `iso_underrun`, which stays set until flush, and `ep_irq` pulses in the next cycle.
- R9: With `cfg_iso` = 0, a `tok_in` that finds no ready packet pulses `tok_nak` for one cycle in the next cycle and changes nothing else.
- R10: `fw_flush` empties both buffers, aborts any transfer and clears `pkt_rdy`, `fifo_not_empty` and `iso_underrun` at that edge. Configuration inputs may change only in a flush cycle.
- R11: A write to a fill buffer that is already armed, or that already holds its capacity (DEPTH single, DEPTH/2 double), is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| cfg_dbuf | input | 1 | 1 = double-buffer mode |
| cfg_iso | input | 1 | 1 = isochronous endpoint |
| cfg_autoset | input | 1 | 1 = arm automatically at MAX_PKT bytes |
| fw_wr | input | 1 | Firmware byte write strobe |
| fw_wdata | input | 8 | Firmware byte |
| fw_arm | input | 1 | Firmware packet-ready strobe |
| fw_flush | input | 1 | Discard all buffered packets |
| tok_in | input | 1 | Host IN token strobe |
| tok_ack | input | 1 | Host acknowledge strobe |
| pkt_rdy | output | 1 | Ready flag of the fill buffer |
| fifo_not_empty | output | 1 | Store holds unretired bytes |
| iso_underrun | output | 1 | Sticky isochronous underrun flag |
| tok_nak | output | 1 | One-cycle NAK indication |
| ep_irq | output | 1 | One-cycle endpoint IN interrupt |
| tx_valid | output | 1 | A packet byte is on tx_data |
| tx_data | output | 8 | Packet byte being sent |
| tx_last | output | 1 | Final byte of the packet |

## Verification
The assertions check these rules on every cycle:
- an armed buffer stays armed and keeps its count until it is retired or flushed;
- data is sent only from an armed buffer, and only an armed buffer is retired;
- `tx_last` never appears without `tx_valid`;
- the underrun flag is sticky;
- flush clears the status;
- NAK and the interrupt never coincide.

Some behaviour only the bench's scenarios and its reference model can show:
- byte order, and the exact number of bytes sent;
- the alternating use of the two halves;
- the cycle in which automatic arming takes effect;
- a retried send;
- the double-buffer case where the ready flag and the not-empty flag disagree.

// File: rtl/in_ep_txbuf_pkg.sv
package in_ep_txbuf_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SEND = 2'd1,
    SQ_WAIT = 2'd2
  } seq_state_e;

endpackage

// File: rtl/in_ep_txbuf_slot.sv
// One packet buffer's bookkeeping: byte count and ready flag.
module in_ep_txbuf_slot #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_hit,
  input  logic          arm,
  input  logic          retire,
  output logic [CW-1:0] cnt,
  output logic          rdy
);

  logic [CW-1:0] cnt_d;
  logic          rdy_d;
  logic          upd;

  always_comb begin
    cnt_d = cnt;
    rdy_d = rdy;
    if (clr || retire) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else begin
      if (wr_hit) cnt_d = cnt + CW'(1);
      if (arm)    rdy_d = 1'b1;
    end
  end

  assign upd = clr | retire | wr_hit | arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      rdy <= 1'b0;
    end else if (upd) begin
      cnt <= cnt_d;
      rdy <= rdy_d;
    end
  end

  // An armed buffer stays armed until it is retired or flushed.
  assert_arm_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !clr && !retire) |=> rdy);

  // An armed buffer accepts no further bytes.
  assert_armed_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !clr && !retire) |=> $stable(cnt));

endmodule

// File: rtl/in_ep_txbuf_seq.sv
// Token sequencer: streams the head packet, waits for acknowledge, retires.
module in_ep_txbuf_seq
  import in_ep_txbuf_pkg::*;
#(
  parameter int CW = 5,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          tok_in,
  input  logic          ack,
  input  logic          iso,
  input  logic          head_rdy,
  input  logic [CW-1:0] head_cnt,
  output logic [IW-1:0] send_idx,
  output logic          sending,
  output logic          last_byte,
  output logic          retire,
  output logic          nak_set,
  output logic          und_set
);

  seq_state_e    st, st_d;
  logic [IW-1:0] idx_d;
  logic [CW-1:0] idx_ext;
  logic          upd;

  assign idx_ext   = CW'(send_idx);
  assign sending   = (st == SQ_SEND);
  assign last_byte = sending && ((idx_ext + CW'(1)) == head_cnt);

  always_comb begin
    st_d    = st;
    idx_d   = send_idx;
    retire  = 1'b0;
    nak_set = 1'b0;
    und_set = 1'b0;
    if (flush) begin
      st_d  = SQ_IDLE;
      idx_d = '0;
    end else begin
      unique case (st)
        SQ_IDLE: begin
          if (tok_in) begin
            if (head_rdy) begin
              idx_d = '0;
              if (head_cnt == '0) begin
                if (iso) retire = 1'b1;
                else     st_d   = SQ_WAIT;
              end else begin
                st_d = SQ_SEND;
              end
            end else if (iso) begin
              und_set = 1'b1;
            end else begin
              nak_set = 1'b1;
            end
          end
        end
        SQ_SEND: begin
          if (last_byte) begin
            if (iso) begin
              retire = 1'b1;
              st_d   = SQ_IDLE;
            end else begin
              st_d = SQ_WAIT;
            end
          end else begin
            idx_d = send_idx + IW'(1);
          end
        end
        SQ_WAIT: begin
          if (ack) begin
            retire = 1'b1;
            st_d   = SQ_IDLE;
          end else if (tok_in && head_cnt != '0) begin
            st_d  = SQ_SEND;
            idx_d = '0;
          end
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  assign upd = flush | tok_in | ack | (st != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      send_idx <= '0;
    end else if (upd) begin
      st       <= st_d;
      send_idx <= idx_d;
    end
  end

  // Bytes only ever leave an armed buffer.
  assert_send_from_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sending |-> head_rdy);

  // Only an armed buffer can be retired.
  assert_retire_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> head_rdy);

endmodule

// File: rtl/in_ep_txbuf.sv
// Transmit buffer controller for one IN endpoint.
module in_ep_txbuf #(
  parameter int DEPTH   = 16,
  parameter int MAX_PKT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_dbuf,
  input  logic       cfg_iso,
  input  logic       cfg_autoset,
  input  logic       fw_wr,
  input  logic [7:0] fw_wdata,
  input  logic       fw_arm,
  input  logic       fw_flush,
  input  logic       tok_in,
  input  logic       tok_ack,
  output logic       pkt_rdy,
  output logic       fifo_not_empty,
  output logic       iso_underrun,
  output logic       tok_nak,
  output logic       ep_irq,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_last
);

  localparam int HALF  = DEPTH / 2;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int AW    = $clog2(DEPTH);
  localparam int NSLOT = 2;

  logic [CW-1:0] slot_cnt [NSLOT];
  logic [NSLOT-1:0] slot_rdy;

  logic          wsel, rsel, wsel_d, rsel_d;
  logic [CW-1:0] fill_cnt, head_cnt, cap;
  logic          fill_rdy, head_rdy;
  logic          wr_ok, auto_hit, arm_fill;
  logic [CW-1:0] wr_sum, rd_sum;
  logic [AW-1:0] wr_addr, rd_addr, send_idx;
  logic          sending, last_byte, seq_retire, nak_set, und_set;
  logic          und_q, und_d, nak_q, irq_q, irq_d;
  logic [7:0]    mem [DEPTH];

  // ---------------- fill side ----------------
  assign fill_cnt = slot_cnt[wsel];
  assign fill_rdy = slot_rdy[wsel];
  assign cap      = cfg_dbuf ? CW'(HALF) : CW'(DEPTH);
  assign wr_ok    = fw_wr && !fw_flush && !fill_rdy && (fill_cnt < cap);
  assign auto_hit = cfg_autoset && wr_ok && ((fill_cnt + CW'(1)) == CW'(MAX_PKT));
  assign arm_fill = !fw_flush && !fill_rdy && (fw_arm || auto_hit);

  assign wr_sum  = (cfg_dbuf && wsel) ? fill_cnt + CW'(HALF) : fill_cnt;
  assign wr_addr = wr_sum[AW-1:0];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_addr] <= fw_wdata;
  end

  // ---------------- drain side ----------------
  assign head_cnt = slot_cnt[rsel];
  assign head_rdy = slot_rdy[rsel];
  assign rd_sum   = (cfg_dbuf && rsel) ? CW'(send_idx) + CW'(HALF) : CW'(send_idx);
  assign rd_addr  = rd_sum[AW-1:0];

  // ---------------- buffer slots ----------------
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic hit_w, hit_r;
    assign hit_w = (wsel == 1'(s));
    assign hit_r = (rsel == 1'(s));
    in_ep_txbuf_slot #(.CW(CW)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (fw_flush),
      .wr_hit (wr_ok && hit_w),
      .arm    (arm_fill && hit_w),
      .retire (seq_retire && hit_r),
      .cnt    (slot_cnt[s]),
      .rdy    (slot_rdy[s])
    );
  end

  in_ep_txbuf_seq #(.CW(CW), .IW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (fw_flush),
    .tok_in    (tok_in),
    .ack       (tok_ack),
    .iso       (cfg_iso),
    .head_rdy  (head_rdy),
    .head_cnt  (head_cnt),
    .send_idx  (send_idx),
    .sending   (sending),
    .last_byte (last_byte),
    .retire    (seq_retire),
    .nak_set   (nak_set),
    .und_set   (und_set)
  );

  // ---------------- ping-pong selectors and status ----------------
  always_comb begin
    wsel_d = wsel;
    rsel_d = rsel;
    if (fw_flush) begin
      wsel_d = 1'b0;
      rsel_d = 1'b0;
    end else begin
      if (arm_fill && cfg_dbuf)   wsel_d = ~wsel;
      if (seq_retire && cfg_dbuf) rsel_d = ~rsel;
    end
    und_d = fw_flush ? 1'b0 : (und_q | und_set);
    irq_d = seq_retire | und_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel  <= 1'b0;
      rsel  <= 1'b0;
      und_q <= 1'b0;
      nak_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (fw_flush || arm_fill)   wsel <= wsel_d;
      if (fw_flush || seq_retire) rsel <= rsel_d;
      if (fw_flush || und_set)    und_q <= und_d;
      nak_q <= nak_set;
      irq_q <= irq_d;
    end
  end

  assign pkt_rdy        = fill_rdy;
  assign fifo_not_empty = (slot_cnt[0] != '0) || (slot_cnt[1] != '0);
  assign iso_underrun   = und_q;
  assign tok_nak        = nak_q;
  assign ep_irq         = irq_q;
  assign tx_valid       = sending;
  assign tx_data        = mem[rd_addr];
  assign tx_last        = last_byte;

  assert_last_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_underrun && !fw_flush) |=> iso_underrun);

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fw_flush |=> (!pkt_rdy && !fifo_not_empty && !iso_underrun && !tx_valid));

  assert_nak_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tok_nak |-> !ep_irq);

endmodule

// File: tb/in_ep_txbuf_test.sv
module in_ep_txbuf_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int MAX_PKT    = 8;
  localparam int HALF       = DEPTH / 2;

  logic clk, rst_n;
  logic cfg_dbuf, cfg_iso, cfg_autoset;
  logic fw_wr, fw_arm, fw_flush, tok_in, tok_ack;
  logic [7:0] fw_wdata;
  logic pkt_rdy, fifo_not_empty, iso_underrun, tok_nak, ep_irq;
  logic tx_valid, tx_last;
  logic [7:0] tx_data;

  in_ep_txbuf #(.DEPTH(DEPTH), .MAX_PKT(MAX_PKT)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_dbuf(cfg_dbuf), .cfg_iso(cfg_iso), .cfg_autoset(cfg_autoset),
    .fw_wr(fw_wr), .fw_wdata(fw_wdata), .fw_arm(fw_arm), .fw_flush(fw_flush),
    .tok_in(tok_in), .tok_ack(tok_ack),
    .pkt_rdy(pkt_rdy), .fifo_not_empty(fifo_not_empty),
    .iso_underrun(iso_underrun), .tok_nak(tok_nak), .ep_irq(ep_irq),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // ---------------- behavioural reference model ----------------
  logic [7:0] qa[$];
  logic [7:0] qb[$];
  bit   mr0, mr1;
  int   mw, mrs, mst, midx;
  bit   mund, mnak, mirq;

  function automatic int qsize(int s);
    return (s == 0) ? qa.size() : qb.size();
  endfunction

  function automatic logic [7:0] qget(int s, int i);
    if (s == 0) return (i < qa.size()) ? qa[i] : 8'h00;
    return (i < qb.size()) ? qb[i] : 8'h00;
  endfunction

  function automatic bit rget(int s);
    return (s == 0) ? mr0 : mr1;
  endfunction

  task automatic rset(int s, bit v);
    if (s == 0) mr0 = v; else mr1 = v;
  endtask

  task automatic model_clear();
    qa.delete(); qb.delete();
    mr0 = 0; mr1 = 0; mw = 0; mrs = 0; mst = 0; midx = 0;
    mund = 0; mnak = 0; mirq = 0;
  endtask

  task automatic model_step();
    int cap, hs;
    bit ret, us, nk, wok, aut, prdy;
    if (fw_flush) begin
      model_clear();
      return;
    end
    cap = cfg_dbuf ? HALF : DEPTH;
    hs  = qsize(mrs);
    ret = 0; us = 0; nk = 0;
    case (mst)
      0: if (tok_in) begin
           if (rget(mrs)) begin
             midx = 0;
             if (hs == 0) begin
               if (cfg_iso) ret = 1; else mst = 2;
             end else mst = 1;
           end else if (cfg_iso) us = 1;
           else nk = 1;
         end
      1: if (midx == hs - 1) begin
           if (cfg_iso) begin ret = 1; mst = 0; end
           else mst = 2;
         end else midx++;
      default: if (tok_ack) begin ret = 1; mst = 0; end
               else if (tok_in && hs != 0) begin mst = 1; midx = 0; end
    endcase
    prdy = rget(mw);
    wok  = fw_wr && !prdy && (qsize(mw) < cap);
    if (wok) begin
      if (mw == 0) qa.push_back(fw_wdata); else qb.push_back(fw_wdata);
    end
    aut = cfg_autoset && wok && (qsize(mw) == MAX_PKT);
    if (!prdy && (fw_arm || aut)) begin
      rset(mw, 1);
      if (cfg_dbuf) mw = 1 - mw;
    end
    if (ret) begin
      if (mrs == 0) qa.delete(); else qb.delete();
      rset(mrs, 0);
      if (cfg_dbuf) mrs = 1 - mrs;
    end
    mund = mund | us;
    mnak = nk;
    mirq = ret | us;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_clear();
    else model_step();
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 pkt_rdy", pkt_rdy, rget(mw));
      chk("R4 fifo_not_empty", fifo_not_empty, (qa.size() != 0 || qb.size() != 0));
      chk("R8 iso_underrun", iso_underrun, mund);
      chk("R9 tok_nak", tok_nak, mnak);
      chk("R7 ep_irq", ep_irq, mirq);
      chk("R6 tx_valid", tx_valid, (mst == 1));
      if (mst == 1) begin
        chk("R6 tx_data", tx_data, qget(mrs, midx));
        chk("R6 tx_last", tx_last, (midx == qsize(mrs) - 1));
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  // ---------------- stimulus ----------------
  task automatic drv(bit w, logic [7:0] d, bit a, bit f, bit t, bit k);
    @(negedge clk); #1;
    fw_wr = w; fw_wdata = d; fw_arm = a; fw_flush = f; tok_in = t; tok_ack = k;
  endtask

  task automatic idle(int n);
    repeat (n) drv(0, 8'h00, 0, 0, 0, 0);
  endtask

  task automatic wr_bytes(int n, int base);
    for (int i = 0; i < n; i++) drv(1, 8'(base + i), 0, 0, 0, 0);
  endtask

  task automatic reconfig(bit db, bit iso, bit au);
    @(negedge clk); #1;
    cfg_dbuf = db; cfg_iso = iso; cfg_autoset = au;
    fw_wr = 0; fw_arm = 0; fw_flush = 1; tok_in = 0; tok_ack = 0;
  endtask

  initial begin
    int nvalid;
    rst_n = 0; cfg_dbuf = 0; cfg_iso = 0; cfg_autoset = 0;
    fw_wr = 0; fw_wdata = 0; fw_arm = 0; fw_flush = 0; tok_in = 0; tok_ack = 0;
    repeat (3) @(negedge clk);
    chk("R1 pkt_rdy in reset", pkt_rdy, 0);
    chk("R1 tx_valid in reset", tx_valid, 0);
    rst_n = 1;
    idle(2);
    chk("R1 pkt_rdy", pkt_rdy, 0);
    chk("R1 fifo_not_empty", fifo_not_empty, 0);
    chk("R1 ep_irq", ep_irq, 0);
    chk("R1 iso_underrun", iso_underrun, 0);

    // single buffer, firmware arm, send, acknowledge
    wr_bytes(3, 8'h10);
    drv(0, 0, 1, 0, 0, 0);
    idle(1);
    chk("R2 armed by firmware", pkt_rdy, 1);
    chk("R4 data held", fifo_not_empty, 1);
    drv(0, 0, 0, 0, 1, 0);
    idle(1);
    chk("R6 first byte valid", tx_valid, 1);
    chk("R6 first byte value", tx_data, 8'h10);
    idle(3);
    drv(0, 0, 0, 0, 0, 1);
    idle(1);
    chk("R7 irq after ack", ep_irq, 1);
    chk("R4 empty after retire", fifo_not_empty, 0);

    // NAK when nothing is ready
    drv(0, 0, 0, 0, 1, 0);
    idle(1);
    chk("R9 nak pulse", tok_nak, 1);
    chk("R9 no irq", ep_irq, 0);

    // write to armed buffer dropped; overfull buffer dropped
    wr_bytes(2, 8'h20);
    drv(0, 0, 1, 0, 0, 0);
    drv(1, 8'hEE, 0, 0, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    idle(4);
    drv(0, 0, 0, 0, 0, 1);
    wr_bytes(DEPTH + 2, 8'h40);
    drv(0, 0, 1, 0, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    nvalid = 0;
    for (int i = 0; i < DEPTH + 4; i++) begin
      idle(1);
      if (tx_valid) nvalid++;
    end
    chk("R11 bytes sent capped at DEPTH", nvalid, DEPTH);
    drv(0, 0, 0, 0, 0, 1);

    // automatic arm
    reconfig(0, 0, 1);
    wr_bytes(3, 8'h60);
    idle(1);
    chk("R3 short packet not armed", pkt_rdy, 0);
    wr_bytes(MAX_PKT - 3, 8'h63);
    idle(1);
    chk("R3 full packet armed", pkt_rdy, 1);
    drv(0, 0, 0, 0, 1, 0);
    idle(MAX_PKT + 1);
    drv(0, 0, 0, 0, 0, 1);

    // retry token while waiting for acknowledge
    reconfig(0, 0, 0);
    wr_bytes(2, 8'h70);
    drv(0, 0, 1, 0, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    idle(3);
    drv(0, 0, 0, 0, 1, 0);
    idle(1);
    chk("R6 retry resends", tx_valid, 1);
    chk("R6 retry first byte", tx_data, 8'h70);
    idle(2);
    drv(0, 0, 0, 0, 0, 1);

    // double buffer
    reconfig(1, 0, 0);
    wr_bytes(3, 8'h80);
    drv(0, 0, 1, 0, 0, 0);
    idle(1);
    chk("R5 fill half free", pkt_rdy, 0);
    chk("R5 data still held", fifo_not_empty, 1);
    wr_bytes(2, 8'h90);
    drv(0, 0, 1, 0, 0, 0);
    idle(1);
    chk("R5 both halves armed", pkt_rdy, 1);
    drv(0, 0, 0, 0, 1, 0);
    idle(4);
    drv(0, 0, 0, 0, 0, 1);
    idle(1);
    chk("R5 second packet remains", fifo_not_empty, 1);
    drv(0, 0, 0, 0, 1, 0);
    idle(1);
    chk("R5 second packet first byte", tx_data, 8'h90);
    idle(2);
    drv(0, 0, 0, 0, 0, 1);
    idle(1);
    chk("R5 empty after last packet", fifo_not_empty, 0);

    // isochronous underrun and retire at last byte
    reconfig(0, 1, 0);
    drv(0, 0, 0, 0, 1, 0);
    idle(1);
    chk("R8 underrun set", iso_underrun, 1);
    chk("R8 irq on underrun", ep_irq, 1);
    wr_bytes(2, 8'hA0);
    drv(0, 0, 1, 0, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    idle(3);
    chk("R7 iso retire irq", ep_irq, 1);
    drv(0, 0, 0, 1, 0, 0);
    idle(1);
    chk("R10 underrun cleared", iso_underrun, 0);
    chk("R10 empty", fifo_not_empty, 0);

    // random traffic in every mode
    for (int m = 0; m < 8; m++) begin
      reconfig(m[0], m[1], m[2]);
      for (int c = 0; c < 250; c++) begin
        drv(($urandom_range(99) < 40), 8'($urandom), ($urandom_range(99) < 8),
            ($urandom_range(199) == 0), ($urandom_range(99) < 15),
            ($urandom_range(99) < 15));
      end
    end
    idle(2);
    finish_run();
  end

endmodule